// File: doc/BRIEF.md
# Sync-Aligned Data Clock Divider

This block derives a data-rate clock from a fast sample clock and pins its phase to an external sync input. When every device in a system sees the same sync edge and holds the same offset, all of their data clocks line up. As a result, input data is latched on the same sample-clock cycle across the devices.

Each rising edge of the sync input becomes a single pulse one sample clock wide, however long the sync input stays high. That pulse presets a free-running 5-bit down-counter to a programmed offset. A mode select then picks one counter bit as the data clock. Bit 0 serves 1x interpolation, bit 1 serves 2x, bit 2 serves 4x, bit 3 serves 8x, and bit 4 serves 8x with zero stuffing.

A sticky flag records any load that moved the counter away from the value it would have reached by itself. The first sync after power-up normally sets it. Later syncs that agree with the running phase leave it alone.

Top module: `dclk_align_top`

## Requirements
- R1: Each 0-to-1 transition of `sync_in` (sampled on the clock) raises `load_pulse` for exactly one clock cycle, in the cycle after the edge is sampled, regardless of how long `sync_in` stays high.
- R2: On the clock edge that ends a `load_pulse` cycle, the counter is preset to `offset`. At every other edge the counter decrements by one, wrapping from 0 to 31.
- R3: `mode` selects the counter bit driving `dclk`: code 0 selects bit 0 (1x), 1 selects bit 1 (2x), 2 selects bit 2 (4x), 3 selects bit 3 (8x), and 4 selects bit 4 (8x zero-stuffed).
- R4: With `offset` = 0, the selected `dclk` rises one cycle after the load edge, in every mode.
- R5: With `offset` = 2 in mode 2 (4x), `dclk` is low after the load and its next rising edge comes three cycles after the load edge.
- R6: `resync_jump` becomes 1 after any load whose `offset` differs from the counter value the decrement would have produced. Once set, it stays 1 until reset.
- R7: A sync arriving when the counter would reach `offset` by itself leaves `resync_jump` at 0.
- R8: Mode codes 5, 6 and 7 select bit 0 (the 1x clock).
- R9: While `rst_n` is low and after its release, the counter starts at 0, and `load_pulse`, `dclk` and `resync_jump` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Sync input, already synchronous to `clk` |
| offset | input | 5 | Counter preset applied on each load |
| mode | input | 3 | Interpolation mode select |
| dclk | output | 1 | Selected data clock |
| load_pulse | output | 1 | One-cycle pulse marking a load |
| resync_jump | output | 1 | Sticky flag: a load broke counter continuity |

## Verification
The bench measures the distance from each load to the next rising edge of `dclk` across offsets and modes. This includes offset 31 in the zero-stuffed mode, which takes a full 32-cycle turn. A counter that counted up instead of down, or that loaded one cycle late, would shift these distances. A long sync high time checks that a level-sensitive detector, which would reload on every cycle, is caught. The undefined mode codes are checked against the 1x clock. A phase-consistent periodic sync is checked to leave the jump flag clear, and a mismatched one to set it permanently, which catches a comparison against the stale count or a flag that clears itself.

// File: rtl/dclk_align_pkg.sv
package dclk_align_pkg;
  localparam int CNT_W  = 5;
  localparam int MODE_W = 3;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [MODE_W-1:0] {
    MODE_X1   = 3'd0,
    MODE_X2   = 3'd1,
    MODE_X4   = 3'd2,
    MODE_X8   = 3'd3,
    MODE_X8ZS = 3'd4
  } mode_e;

  // Divider bit index for a mode code; undefined codes fall back to 1x.
  function automatic logic [2:0] mode_to_bit(input logic [MODE_W-1:0] m);
    logic [2:0] b;
    case (m)
      MODE_X2:   b = 3'd1;
      MODE_X4:   b = 3'd2;
      MODE_X8:   b = 3'd3;
      MODE_X8ZS: b = 3'd4;
      default:   b = 3'd0;
    endcase
    return b;
  endfunction

  // Value the free-running counter reaches on its own at the next edge.
  function automatic cnt_t cnt_step(input cnt_t c);
    return c - cnt_t'(1);
  endfunction
endpackage

// File: rtl/sync_edge_pulse.sv
module sync_edge_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic pulse_o
);
  logic sync_d;
  logic rise_w;

  assign rise_w = sync_in & ~sync_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_d  <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      sync_d  <= sync_in;
      pulse_o <= rise_w;
    end
  end

  // R1
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
  // R1
  pulse_needs_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> sync_d);
endmodule

// File: rtl/phase_divider.sv
module phase_divider
  import dclk_align_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  cnt_t offset_i,
  output cnt_t cnt_o,
  output logic jump_o
);
  cnt_t cnt_q;
  cnt_t natural_w;
  logic mismatch_w;
  logic jump_q;

  assign natural_w  = cnt_step(cnt_q);
  assign mismatch_w = load_i && (offset_i != natural_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      jump_q <= 1'b0;
    end else begin
      cnt_q  <= load_i ? offset_i : natural_w;
      if (mismatch_w) jump_q <= 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign jump_o = jump_q;

  // R2
  load_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(offset_i));
  // R2
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> cnt_q == cnt_t'($past(cnt_q) - cnt_t'(1)));
  // R6
  jump_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump_q |=> jump_q);
  // R7
  no_false_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!jump_q && !mismatch_w) |=> !jump_q);
endmodule

// File: rtl/dclk_align_top.sv
module dclk_align_top
  import dclk_align_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_in,
  input  logic [4:0] offset,
  input  logic [2:0] mode,
  output logic       dclk,
  output logic       load_pulse,
  output logic       resync_jump
);
  logic pulse_w;
  cnt_t cnt_w;
  logic jump_w;

  sync_edge_pulse u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_in (sync_in),
    .pulse_o (pulse_w)
  );

  phase_divider u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (pulse_w),
    .offset_i (offset),
    .cnt_o    (cnt_w),
    .jump_o   (jump_w)
  );

  assign dclk        = cnt_w[mode_to_bit(mode)];
  assign load_pulse  = pulse_w;
  assign resync_jump = jump_w;

  // R4
  zero_offset_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_w && offset == 5'd0) |=> ##1 (rst_n ? dclk : 1'b1));
endmodule

// File: tb/tb_dclk_align_top.sv
module tb_dclk_align_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sync_in;
  logic [4:0] offset;
  logic [2:0] mode;
  logic       dclk, load_pulse, resync_jump;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  dclk_align_top dut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .offset(offset),
    .mode(mode), .dclk(dclk), .load_pulse(load_pulse), .resync_jump(resync_jump)
  );

  // {mode[2:0], offset[4:0], cycles from load edge to next dclk rise[7:0]}
  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    {3'd0, 5'd0,  8'd1},   // R4
    {3'd2, 5'd0,  8'd1},   // R4
    {3'd4, 5'd0,  8'd1},   // R4
    {3'd2, 5'd2,  8'd3},   // R5
    {3'd0, 5'd2,  8'd1},   // R3
    {3'd1, 5'd2,  8'd3},   // R3
    {3'd2, 5'd5,  8'd6},   // R3
    {3'd3, 5'd8,  8'd9},   // R3
    {3'd4, 5'd17, 8'd18},  // R3
    {3'd4, 5'd31, 8'd32},  // R3
    {3'd5, 5'd6,  8'd1},   // R8
    {3'd7, 5'd3,  8'd2}    // R8
  };

  function automatic int exp_bit(input logic [2:0] m);
    return (m > 3'd4) ? 0 : int'(m);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sync_in = 1'b0; offset = '0; mode = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(load_pulse == 0 && dclk == 0 && resync_jump == 0, "R9", {load_pulse, dclk, resync_jump}, 0);

    // R7: first sync matches the running count (reset 0 -> 31 -> 30)
    rst_n = 1'b1; sync_in = 1'b1; offset = 5'd30; mode = 3'd4;
    @(negedge clk); sync_in = 1'b0;
    check(load_pulse == 1, "R1", load_pulse, 1);
    @(negedge clk);
    check(resync_jump == 0, "R7", resync_jump, 0);
    // periodic sync, 32-cycle period, same offset: no jump
    for (int p = 0; p < 3; p++) begin
      repeat (30) @(negedge clk);
      sync_in = 1'b1; @(negedge clk); sync_in = 1'b0; @(negedge clk);
    end
    check(resync_jump == 0, "R7", resync_jump, 0);

    // R1: long high time gives one pulse
    begin
      int cnt_p = 0;
      sync_in = 1'b1;
      for (int i = 0; i < 12; i++) begin @(negedge clk); if (load_pulse) cnt_p++; end
      sync_in = 1'b0;
      for (int i = 0; i < 4; i++) begin @(negedge clk); if (load_pulse) cnt_p++; end
      check(cnt_p == 1, "R1", cnt_p, 1);
    end

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic prev;
      int found;
      mode = VEC[v][15:13]; offset = VEC[v][12:8];
      repeat (3) @(negedge clk);
      sync_in = 1'b1;
      @(negedge clk);
      check(load_pulse == 1, "R1", load_pulse, 1);
      @(negedge clk);
      sync_in = 1'b0;
      check(load_pulse == 0, "R1", load_pulse, 0);
      check(dclk == offset[exp_bit(mode)], "R2", dclk, offset[exp_bit(mode)]);
      prev = dclk; found = -1;
      for (int k = 1; k <= 40; k++) begin
        @(negedge clk);
        if (found < 0 && dclk && !prev) found = k;
        prev = dclk;
      end
      check(found == int'(VEC[v][7:0]), (mode > 4) ? "R8" : (offset == 0 ? "R4" : (mode == 2 && offset == 2 ? "R5" : "R3")),
            found, int'(VEC[v][7:0]));
    end

    // R6: jump flag set by mismatching load, then sticky
    check(resync_jump == 1, "R6", resync_jump, 1);
    rst_n = 1'b0; @(negedge clk);
    check(resync_jump == 0, "R9", resync_jump, 0);
    rst_n = 1'b1; mode = 3'd0; offset = 5'd9;
    repeat (5) @(negedge clk);
    sync_in = 1'b1; @(negedge clk); @(negedge clk); sync_in = 1'b0;
    check(resync_jump == 1, "R6", resync_jump, 1);
    repeat (20) @(negedge clk);
    check(resync_jump == 1, "R6", resync_jump, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule